// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a clocked host and an external static RAM with 65,536 words of 4 bits and separate data-in and data-out pins. The host issues one read or write at a time with a single-cycle request while the controller is not busy. The controller then generates the memory's active-low select and write strobes from a free-running clock and holds the address and write data steady for the whole access. It captures the word the memory returns on a read and reports it with a one-cycle valid pulse.

Every analog timing minimum of the memory is expressed as a parameter in clock cycles: the read access length, the write-strobe pulse width, the data setup before the strobe's rising edge, and the full write cycle. The controller rounds up so that no minimum is ever shortened. The strobe stays low for the larger of the pulse width and the data setup. After the strobe rises, select stays low long enough to complete the write cycle and for at least one clock of hold. Between accesses the memory is deselected for at least one cycle, so it drops into standby whenever the host is quiet.

Top module: `sram_cyc_ctrl`

## Requirements
- R1: During and right after synchronous reset, `mem_cs_n` and `mem_wr_n` are 1, `busy` is 0 and `rd_valid` is 0.
- R2: A read accepted at a clock edge (`cmd_req`=1, `cmd_write`=0, `busy`=0) drives `mem_cs_n`=0 with `mem_wr_n`=1 for exactly RD_CYC cycles starting after that edge.
- R3: `rd_data` takes the value of `mem_dout` at the edge that ends the last read-access cycle, and `rd_valid` is 1 for exactly the one following cycle, the same cycle in which `mem_cs_n` has returned to 1.
- R4: A write accepted at a clock edge (`cmd_write`=1) drives `mem_wr_n`=0 and `mem_cs_n`=0 for max(WE_PULSE, WD_SETUP) cycles starting after that edge.
- R5: After `mem_wr_n` rises, `mem_cs_n` stays 0 for max(1, WR_CYC − max(WE_PULSE, WD_SETUP)) cycles, and `mem_din` keeps the accepted write data throughout the strobe and this tail.
- R6: `busy` is 1 in every cycle in which an access is in progress (`mem_cs_n`=0). A `cmd_req` sampled while `busy`=1 is ignored and changes no output.
- R7: `mem_cs_n` is 1 in every cycle with no access in progress, so consecutive accesses are separated by at least one deselected cycle.
- R8: `mem_wr_n` is never 0 while `mem_cs_n` is 1, and stays 1 throughout a read.
- R9: `mem_addr` equals the address accepted with the command in every cycle of the access, including the write tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_req | input | 1 | Command request, taken when busy is 0 |
| cmd_write | input | 1 | 1 = write command, 0 = read command |
| cmd_addr | input | 16 | Word address of the command |
| cmd_wdata | input | 4 | Write data of the command |
| busy | output | 1 | Access in progress, new requests ignored |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds the read word |
| rd_data | output | 4 | Captured read word |
| mem_addr | output | 16 | Address to the memory |
| mem_din | output | 4 | Write data to the memory's input pins |
| mem_dout | input | 4 | Data from the memory's output pins |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |

## Verification
The hardest case to reach is a command arriving in the single cycle where one access has just finished. At that moment `rd_valid` is still high, or the write tail has just released select, and the controller must take the new command without skipping the deselected cycle. The bench issues commands back to back with no idle gap on the host side, so every such boundary is hit. It also raises a request with a different address while busy. The bench's memory model commits a write only on the strobe's rising edge while select is low. A read that follows a write therefore returns correct data only if the address and data were still held when the strobe rose.

// File: rtl/sram_cyc_pkg.sv
package sram_cyc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WLOW  = 2'd2,
    PH_WTAIL = 2'd3
  } phase_e;

  // Strobe-low length: both the pulse width and the data setup end at the
  // strobe's rising edge, and data is driven when the strobe falls.
  function automatic int strobe_len(input int pulse, input int setup);
    return (pulse > setup) ? pulse : setup;
  endfunction

  // Cycles with select low after the strobe rises: finish the cycle time,
  // and never fewer than one clock of address/data hold.
  function automatic int tail_len(input int cyc, input int low);
    return ((cyc - low) > 1) ? (cyc - low) : 1;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Counter width to hold values 0 .. n-1.
  function automatic int cnt_bits(input int n);
    return (n < 3) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/sram_cmd_latch.sv
module sram_cmd_latch #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (take) begin
      addr_q <= addr_in;
      data_q <= data_in;
    end
  end
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              grab,
  input  logic [DATA_W-1:0] pins,
  output logic [DATA_W-1:0] word_q,
  output logic              valid_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= grab;
      if (grab) word_q <= pins;
    end
  end

  // R3: the valid flag is a single-cycle pulse
  p_valid_single_r3: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q);
endmodule

// File: rtl/sram_cyc_ctrl.sv
module sram_cyc_ctrl #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 4,
  parameter int RD_CYC   = 2,
  parameter int WE_PULSE = 1,
  parameter int WD_SETUP = 1,
  parameter int WR_CYC   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_req,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              busy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_din,
  input  logic [DATA_W-1:0] mem_dout,
  output logic              mem_cs_n,
  output logic              mem_wr_n
);
  import sram_cyc_pkg::*;

  localparam int LOW_LEN  = strobe_len(WE_PULSE, WD_SETUP);
  localparam int TAIL_LEN = tail_len(WR_CYC, LOW_LEN);
  localparam int MAX_LEN  = max3(RD_CYC, LOW_LEN, TAIL_LEN);
  localparam int CNT_W    = cnt_bits(MAX_LEN);
  localparam int RUN_W    = CNT_W + 2;
  localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] LOW_LD  = CNT_W'(LOW_LEN - 1);
  localparam logic [CNT_W-1:0] TAIL_LD = CNT_W'(TAIL_LEN - 1);

  phase_e           phase_q, phase_d;
  logic             accept, phase_last, grab_now;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;

  // named internal events
  assign accept   = cmd_req && (phase_q == PH_IDLE);
  assign grab_now = (phase_q == PH_READ) && phase_last;

  always_comb begin
    phase_d  = phase_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (phase_q)
      PH_IDLE: if (accept) begin
        tmr_load = 1'b1;
        tmr_val  = cmd_write ? LOW_LD : RD_LD;
        phase_d  = cmd_write ? PH_WLOW : PH_READ;
      end
      PH_READ: if (phase_last) phase_d = PH_IDLE;
      PH_WLOW: if (phase_last) begin
        tmr_load = 1'b1;
        tmr_val  = TAIL_LD;
        phase_d  = PH_WTAIL;
      end
      PH_WTAIL: if (phase_last) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  // strobes registered from the next phase so the pins never glitch
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      mem_cs_n <= 1'b1;
      mem_wr_n <= 1'b1;
    end else begin
      phase_q  <= phase_d;
      mem_cs_n <= (phase_d == PH_IDLE);
      mem_wr_n <= (phase_d != PH_WLOW);
    end
  end

  assign busy = (phase_q != PH_IDLE);

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .last(phase_last)
  );

  sram_cmd_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst(rst), .take(accept), .addr_in(cmd_addr), .data_in(cmd_wdata),
    .addr_q(mem_addr), .data_q(mem_din)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .grab(grab_now), .pins(mem_dout),
    .word_q(rd_data), .valid_q(rd_valid)
  );

  // run-length counters, used only by the checks below
  logic [RUN_W-1:0] wr_low_run, cs_low_run;
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_low_run <= '0;
      cs_low_run <= '0;
    end else begin
      wr_low_run <= mem_wr_n ? '0 : wr_low_run + 1'b1;
      cs_low_run <= mem_cs_n ? '0 : cs_low_run + 1'b1;
    end
  end

  // R8: the write strobe only falls inside a selected access
  p_strobe_in_select_r8: assert property (@(posedge clk) disable iff (rst)
    !mem_wr_n |-> !mem_cs_n);
  // R7: with no access in progress the memory is deselected
  p_idle_deselect_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> mem_cs_n);
  // R9: the address does not move during an access
  p_addr_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(mem_addr));
  // R4: the strobe was low for the full rounded-up length
  p_strobe_len_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_wr_n) |-> (wr_low_run == RUN_W'(LOW_LEN)));
  // R2: a read kept select low for exactly the access length
  p_read_len_r2: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (cs_low_run == RUN_W'(RD_CYC)));
endmodule

// File: tb/sram_cyc_ctrl_tb_top.sv
module sram_cyc_ctrl_tb_top;
  localparam int RD  = 3;
  localparam int PW  = 1;
  localparam int SU  = 2;
  localparam int WC  = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_req = 1'b0, cmd_write = 1'b0;
  logic [15:0] cmd_addr = '0;
  logic [3:0]  cmd_wdata = '0;
  logic        busy, rd_valid, mem_cs_n, mem_wr_n;
  logic [3:0]  rd_data, mem_din;
  logic [3:0]  mem_dout = 4'hE;
  logic [15:0] mem_addr;

  int vectors = 0, miscompares = 0, cycles = 0;
  bit checking = 1'b0;

  always #5 clk = ~clk;

  sram_cyc_ctrl #(.RD_CYC(RD), .WE_PULSE(PW), .WD_SETUP(SU), .WR_CYC(WC)) dut_i (
    .clk(clk), .rst(rst), .cmd_req(cmd_req), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .rd_valid(rd_valid),
    .rd_data(rd_data), .mem_addr(mem_addr), .mem_din(mem_din), .mem_dout(mem_dout),
    .mem_cs_n(mem_cs_n), .mem_wr_n(mem_wr_n)
  );

  // ---------------- memory model driven only by the pins ----------------
  logic [3:0] cells [int];
  logic       prev_wr = 1'b1;
  function automatic logic [3:0] blank(input logic [15:0] a);
    return a[3:0] ^ 4'h9;
  endfunction
  always @(negedge clk) begin
    if (!rst && prev_wr == 1'b0 && mem_wr_n == 1'b1 && mem_cs_n == 1'b0)
      cells[int'(mem_addr)] = mem_din;
    prev_wr = mem_wr_n;
    if (!mem_cs_n && mem_wr_n)
      mem_dout = cells.exists(int'(mem_addr)) ? cells[int'(mem_addr)] : blank(mem_addr);
    else
      mem_dout = 4'hE;
  end

  // ---------------- cycle-by-cycle reference model ----------------
  typedef struct {
    bit cs_n; bit wr_n; bit bsy; bit rv;
    logic [15:0] a; logic [3:0] d; logic [3:0] rw;
    bit chk_a; bit chk_d; string tag;
  } exp_t;

  exp_t       plan_q[$];
  exp_t       cur;
  logic [3:0] shadow [int];

  function automatic exp_t idle_e();
    exp_t e;
    e.cs_n = 1; e.wr_n = 1; e.bsy = 0; e.rv = 0; e.a = '0; e.d = '0; e.rw = '0;
    e.chk_a = 0; e.chk_d = 0; e.tag = "R7";
    return e;
  endfunction

  function automatic exp_t act_e(bit wr_low, logic [15:0] a, logic [3:0] d, bit chkd, string tag);
    exp_t e;
    e = idle_e();
    e.cs_n = 0; e.wr_n = !wr_low; e.bsy = 1; e.a = a; e.d = d;
    e.chk_a = 1; e.chk_d = chkd; e.tag = tag;
    return e;
  endfunction

  task automatic plan_cmd(bit w, logic [15:0] a, logic [3:0] d);
    exp_t e;
    int lowc, total;
    if (!w) begin
      for (int i = 0; i < RD; i++) plan_q.push_back(act_e(0, a, d, 0, "R2"));
      e = idle_e(); e.rv = 1; e.tag = "R3";
      e.rw = shadow.exists(int'(a)) ? shadow[int'(a)] : blank(a);
      plan_q.push_back(e);
    end else begin
      shadow[int'(a)] = d;
      lowc = 0;
      while (lowc < PW || lowc < SU) lowc++;
      total = lowc;
      for (int i = 0; i < lowc; i++) plan_q.push_back(act_e(1, a, d, 1, "R4"));
      do begin
        plan_q.push_back(act_e(0, a, d, 1, "R5"));
        total++;
      end while (total < WC);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      plan_q.delete();
      cur = idle_e();
    end else begin
      if (!cur.bsy && cmd_req) plan_cmd(cmd_write, cmd_addr, cmd_wdata);
      cur = (plan_q.size() > 0) ? plan_q.pop_front() : idle_e();
    end
  end

  task automatic fail_line(string tag, string what, int act, int exp);
    miscompares++;
    $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
  endtask

  always @(negedge clk) begin
    if (checking && !rst) begin
      bit bad;
      bad = 0;
      vectors++;
      if (mem_cs_n !== cur.cs_n) begin fail_line(cur.tag, "mem_cs_n", mem_cs_n, cur.cs_n); bad = 1; end
      if (mem_wr_n !== cur.wr_n) begin fail_line(cur.tag, "mem_wr_n", mem_wr_n, cur.wr_n); bad = 1; end
      if (busy !== cur.bsy && !bad) begin fail_line("R6", "busy", busy, cur.bsy); bad = 1; end
      if (rd_valid !== cur.rv && !bad) begin fail_line("R3", "rd_valid", rd_valid, cur.rv); bad = 1; end
      if (cur.rv && rd_data !== cur.rw && !bad) begin fail_line("R3", "rd_data", rd_data, cur.rw); bad = 1; end
      if (cur.chk_a && mem_addr !== cur.a && !bad) begin fail_line("R9", "mem_addr", mem_addr, cur.a); bad = 1; end
      if (cur.chk_d && mem_din !== cur.d && !bad) begin fail_line("R5", "mem_din", mem_din, cur.d); bad = 1; end
      // R8: strobe never low while deselected
      if (!mem_wr_n && mem_cs_n && !bad) fail_line("R8", "wr_n low while deselected", 0, 1);
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(bit w, logic [15:0] a, logic [3:0] d);
    while (busy) @(negedge clk);
    cmd_req = 1; cmd_write = w; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_req = 0;
  endtask

  // R6: a request raised during an access must be ignored
  task automatic poke_while_busy(logic [15:0] a);
    cmd_req = 1; cmd_write = 1; cmd_addr = a; cmd_wdata = 4'h3;
    @(negedge clk);
    cmd_req = 0; cmd_addr = '0;
  endtask

  bit finished = 0;

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    vectors++;
    if (mem_cs_n !== 1 || mem_wr_n !== 1 || busy !== 0 || rd_valid !== 0)
      fail_line("R1", "reset outputs {cs_n,wr_n,busy,rv}",
                {mem_cs_n, mem_wr_n, busy, rd_valid}, 4'b1100);
    rst = 0;
    checking = 1;
    @(negedge clk);
    vectors++;
    if (mem_cs_n !== 1 || busy !== 0)
      fail_line("R1", "after reset {cs_n,busy}", {mem_cs_n, busy}, 2'b10);

    issue(0, 16'h1234, 0);          // unwritten location
    issue(1, 16'h0000, 4'hA);       // low boundary
    issue(1, 16'hFFFF, 4'h5);       // high boundary
    issue(0, 16'h0000, 0);
    issue(0, 16'hFFFF, 0);
    issue(1, 16'h00F0, 4'h7);
    poke_while_busy(16'h00F0 ^ 16'h0F0F);
    issue(0, 16'h00F0, 0);
    poke_while_busy(16'hBEEF);
    issue(0, 16'hBEEF, 0);          // must still be blank
    for (int i = 0; i < 16; i++) issue(1, 16'(i * 16'h0111), 4'(i ^ 5));
    for (int i = 15; i >= 0; i--) issue(0, 16'(i * 16'h0111), 0);
    repeat (4) @(negedge clk);
    issue(1, 16'h8000, 4'hC);
    issue(1, 16'h8000, 4'h3);       // overwrite back-to-back
    issue(0, 16'h8000, 0);
    repeat (8) @(negedge clk);
    finished = 1;
  end

  initial begin
    while (!finished && cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule